// File: doc/BRIEF.md
# UART Receive Status Flags

This block keeps the receive-side status of a serial port: a receive-full flag, an overrun flag, a framing error flag and a parity error flag. It also holds the data register that the CPU reads. A separate receiver shifter reports each finished word with a one-cycle event. With that event it supplies the word, whether the stop bit was sampled high, and whether the parity check passed.

Software reads the flags with a status-read strobe and takes the byte with a data-read strobe. A flag is cleared only by an ordered pair: first a status read that sees the flag set, then a data read. If a word finishes while the previous one is still unread, that word is thrown away and the overrun flag is raised. The unread word stays in the data register. The framing and parity flags each have an enable input, and together they drive a level error interrupt.

Top module: `uart_rx_flags`

## Requirements
- R1: Reset clears all four flags, the held word and the interrupt. The status word is laid out as bit 0 receive-full, bit 1 overrun, bit 2 framing error, bit 3 parity error.
- R2: A word event while receive-full is clear loads the word into the data register and sets receive-full. Both are visible after the next clock edge.
- R3: An accepted word whose stop bit was sampled low (stop_ok = 0) sets the framing error flag.
- R4: An accepted word that failed the parity check (parity_ok = 0) sets the parity error flag.
- R5: A word event while receive-full is set raises overrun and discards the incoming word. The data register keeps the unread word, and the discarded word's stop and parity results set no flag.
- R6: A data read clears exactly those flags that were set when an earlier status read was made. The clear is visible after the data read's clock edge. A flag that was clear at that status read stays set if it rises before the data read.
- R7: A data read that no armed status read preceded clears nothing.
- R8: If an armed flag is set again by a new event between the status read and the data read, the data read leaves it set.
- R9: err_irq is high exactly while (framing flag AND fe_irq_en) OR (parity flag AND pe_irq_en). It is a level that holds until the flag clears or the enable drops.
- R10: Once receive-full has cleared after an overrun, the next word is accepted normally, even while overrun is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_done | input | 1 | One-cycle event: the shifter finished a word |
| word_data | input | DATA_W | Word from the shifter, valid with word_done |
| stop_ok | input | 1 | Stop bit sampled high, valid with word_done |
| parity_ok | input | 1 | Parity check passed, valid with word_done |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| fe_irq_en | input | 1 | Framing error interrupt enable |
| pe_irq_en | input | 1 | Parity error interrupt enable |
| rx_stat | output | 4 | Status word {parity, framing, overrun, full} |
| rx_data | output | DATA_W | Held received word |
| err_irq | output | 1 | Level error interrupt request |

## Verification
Every piece of internal state shows up at the ports one clock edge after it changes, because flags and data are registered outputs and the interrupt is combinational from them. A lost or stuck arm bit shows up after the next data read, as a flag that should have cleared but stays set, or one that clears without a prior status read. A wrong accept decision shows up after the next word event: the held word changes during an overrun, or a word is refused after receive-full has cleared.

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [DATA_W-1:0] word_data,
  input  logic              stop_ok,
  input  logic              parity_ok,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              fe_irq_en,
  input  logic              pe_irq_en,
  output logic [3:0]        rx_stat,
  output logic [DATA_W-1:0] rx_data,
  output logic              err_irq
);
  localparam int NFLAG = 4;
  localparam int FULL  = 0;
  localparam int OVR   = 1;
  localparam int FERR  = 2;
  localparam int PERR  = 3;

  logic [NFLAG-1:0] flag_q, arm_q, set_v, clr_v;
  logic             accept;

  assign accept = word_done & ~flag_q[FULL];

  always_comb begin
    set_v       = '0;
    set_v[FULL] = accept;
    set_v[OVR]  = word_done & flag_q[FULL];
    set_v[FERR] = accept & ~stop_ok;
    set_v[PERR] = accept & ~parity_ok;
  end

  assign clr_v = {NFLAG{data_rd}} & arm_q & ~set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      arm_q   <= '0;
      rx_data <= '0;
    end else begin
      flag_q <= (flag_q & ~clr_v) | set_v;
      arm_q  <= ((data_rd ? '0 : arm_q) | (stat_rd ? flag_q : '0)) & ~set_v;
      if (accept) rx_data <= word_data;
    end
  end

  assign rx_stat = flag_q;
  assign err_irq = (flag_q[FERR] & fe_irq_en) | (flag_q[PERR] & pe_irq_en);
endmodule

// File: rtl/uart_rx_flags_chk.sv
module uart_rx_flags_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_done,
  input logic [DATA_W-1:0] word_data,
  input logic              stop_ok,
  input logic              parity_ok,
  input logic              data_rd,
  input logic [3:0]        rx_stat,
  input logic [DATA_W-1:0] rx_data,
  input logic              err_irq
);
  assert_accept_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !rx_stat[0] |=> rx_stat[0] && rx_data == $past(word_data));

  assert_frame_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !rx_stat[0] && !stop_ok |=> rx_stat[2]);

  assert_parity_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && !rx_stat[0] && !parity_ok |=> rx_stat[3]);

  assert_overrun_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done && rx_stat[0] |=> rx_stat[1] && $stable(rx_data));

  assert_no_fall_without_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> (rx_stat & $past(rx_stat)) == $past(rx_stat));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stat[3:2] == 2'b00 |-> !err_irq);
endmodule

bind uart_rx_flags uart_rx_flags_chk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_data(word_data),
  .stop_ok(stop_ok), .parity_ok(parity_ok), .data_rd(data_rd),
  .rx_stat(rx_stat), .rx_data(rx_data), .err_irq(err_irq)
);

// File: tb/tb_uart_rx_flags.sv
`timescale 1ns/100ps
module tb_uart_rx_flags;
  logic clk = 0, rst_n = 0;
  logic word_done = 0, stop_ok = 1, parity_ok = 1, stat_rd = 0, data_rd = 0;
  logic fe_irq_en = 0, pe_irq_en = 0;
  logic [7:0] word_data = '0;
  logic [3:0] rx_stat;
  logic [7:0] rx_data;
  logic err_irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  uart_rx_flags #(.DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_data(word_data),
    .stop_ok(stop_ok), .parity_ok(parity_ok), .stat_rd(stat_rd), .data_rd(data_rd),
    .fe_irq_en(fe_irq_en), .pe_irq_en(pe_irq_en),
    .rx_stat(rx_stat), .rx_data(rx_data), .err_irq(err_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] d, logic s_ok, logic p_ok);
    word_data = d; stop_ok = s_ok; parity_ok = p_ok; word_done = 1;
    @(negedge clk);
    word_done = 0; stop_ok = 1; parity_ok = 1;
  endtask

  task automatic read_stat();
    stat_rd = 1; @(negedge clk); stat_rd = 0;
  endtask

  task automatic read_data();
    data_rd = 1; @(negedge clk); data_rd = 0;
  endtask

  task automatic t_reset();
    check("R1 status", rx_stat, 4'b0000);
    check("R1 data", rx_data, 8'h00);
    check("R1 irq", err_irq, 0);
  endtask

  task automatic t_normal();
    send(8'hA5, 1, 1);
    check("R2 full", rx_stat, 4'b0001);
    check("R2 data", rx_data, 8'hA5);
    read_stat(); read_data();
    check("R6 cleared", rx_stat, 4'b0000);
    send(8'h3C, 1, 1);
    check("R2 second data", rx_data, 8'h3C);
    read_stat(); read_data();
    check("R6 second clear", rx_stat, 4'b0000);
  endtask

  task automatic t_errors();
    send(8'h5A, 0, 0);
    check("R3 R4 flags", rx_stat, 4'b1101);
    check("R9 irq off", err_irq, 0);
    fe_irq_en = 1; #0.1;
    check("R9 fe irq", err_irq, 1);
    fe_irq_en = 0; pe_irq_en = 1; #0.1;
    check("R9 pe irq", err_irq, 1);
    read_stat(); read_data();
    check("R6 errors clear", rx_stat, 4'b0000);
    check("R9 irq drops", err_irq, 0);
    pe_irq_en = 0;
    send(8'h01, 0, 1);
    check("R3 framing only", rx_stat, 4'b0101);
    read_stat(); read_data();
    send(8'h02, 1, 0);
    check("R4 parity only", rx_stat, 4'b1001);
    read_stat(); read_data();
  endtask

  task automatic t_no_arm();
    send(8'h77, 1, 1);
    read_data();
    check("R7 data read alone", rx_stat, 4'b0001);
    read_stat(); read_data();
    check("R7 then proper clear", rx_stat, 4'b0000);
  endtask

  task automatic t_overrun();
    send(8'h11, 1, 1);
    send(8'h22, 0, 0);
    check("R5 overrun flags", rx_stat, 4'b0011);
    check("R5 data kept", rx_data, 8'h11);
    read_stat(); read_data();
    check("R5 cleared", rx_stat, 4'b0000);
    send(8'h33, 1, 1);
    check("R10 accepted", rx_data, 8'h33);
    read_stat(); read_data();
  endtask

  task automatic t_delayed();
    send(8'h44, 1, 1);
    read_stat();
    send(8'h55, 1, 1);
    read_data();
    check("R6 only seen flag cleared", rx_stat, 4'b0010);
    send(8'h66, 1, 1);
    check("R10 after overrun status", rx_stat, 4'b0011);
    check("R10 after overrun data", rx_data, 8'h66);
    read_stat(); read_data();
    check("R6 all clear", rx_stat, 4'b0000);
  endtask

  task automatic t_reset_during_seq();
    send(8'h70, 1, 1);
    send(8'h80, 1, 1);
    read_stat();
    send(8'h90, 1, 1);
    read_data();
    check("R8 overrun stays", rx_stat, 4'b0010);
    check("R8 data kept", rx_data, 8'h70);
    read_stat(); read_data();
    check("R8 later clear", rx_stat, 4'b0000);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_normal();
    t_errors();
    t_no_arm();
    t_overrun();
    t_delayed();
    t_reset_during_seq();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule